// File: doc/BRIEF.md
# Configurable IO pin multiplexer

This block sits between the core of a chip and its pads. Each core pin is a bidirectional triple: the core drives a data bit and an active-low output enable toward the pad, and receives an input bit back from the pad. Any of the `NUM_CORE` core pins can be steered onto any of the `NUM_PAD` pads. For each pad, a configuration register holds an enable mask with one bit per core pin. When more than one core pin is enabled on the same pad, a per-core-pin priority register decides which one owns the pad.

The owner of each pad is resolved from the configuration and then held in a register. This leaves the functional data path as a single AND-OR stage driven by one-hot owner vectors. A separate test path carries its own pad data and enables. A final two-way select, controlled by `test_mode`, picks between the test path and the functional path at each pad.

Every core pin input is always driven. It takes the value of the pad it owns. A core pin that owns no pad takes a fixed default bit from a parameter vector.

Top module: `pinmux_fabric`

## Requirements
- R1: After a synchronous reset (`rst` high across a rising edge), every pad mask and every priority is zero. With `test_mode` low, every pad shows `pad_oe_n`=1 and `pad_out`=0, and every `core_in[c]` equals `DEFAULT_IN[c]`.
- R2: A write is taken on a rising edge where `wr_en` is high. Addresses 0 to `NUM_PAD`-1 write the mask of pad `wr_addr`, and `wr_data` bit c enables core pin c. Address `NUM_PAD`+c writes the priority of core pin c from the low `PRIO_W` bits of `wr_data`. The new routing appears at the pads after the second rising edge following the write edge, and not before.
- R3: A pad whose mask enables exactly one core pin c gives `pad_out`=`core_out[c]` and `pad_oe_n`=`core_oe_n[c]`. This holds for every pair of pad and core pin.
- R4: When several core pins are enabled on a pad, the enabled core pin with the numerically largest priority value owns the pad.
- R5: Among enabled core pins that share the largest priority value, the one with the lowest index owns the pad.
- R6: A pad with an all-zero mask drives `pad_oe_n`=1 and `pad_out`=0 in functional mode.
- R7: `core_in[c]` equals `pad_in` of the pad owned by core pin c. If core pin c owns several pads, the pad with the lowest index is used.
- R8: A core pin that owns no pad sees `core_in[c]`=`DEFAULT_IN[c]`, whatever the pad inputs are.
- R9: With `test_mode` high, every pad gives `pad_out`=`test_out` and `pad_oe_n`=`test_oe_n`, and the core pin inputs follow R7 and R8 unchanged.
- R10: Writes to addresses at or above `NUM_PAD`+`NUM_CORE` change no mask and no priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Configuration register address |
| wr_data | input | DATA_W | Configuration write data |
| core_out | input | NUM_CORE | Data from each core pin toward its pad |
| core_oe_n | input | NUM_CORE | Active-low output enable from each core pin |
| core_in | output | NUM_CORE | Pad data returned to each core pin |
| pad_in | input | NUM_PAD | Data received at each pad |
| pad_out | output | NUM_PAD | Data driven to each pad |
| pad_oe_n | output | NUM_PAD | Active-low output enable of each pad |
| test_mode | input | 1 | Selects the test path at the pads |
| test_out | input | NUM_PAD | Test-path pad data |
| test_oe_n | input | NUM_PAD | Test-path active-low pad enables |

## Verification
The assertions check on every cycle that each pad has at most one owner and that an unowned pad is tristated in functional mode. They also check that an unowned core pin reads its default, that the test path controls the pads whenever `test_mode` is high, and that the routing holds steady when no write has occurred. Only the bench's scenarios can show which core pin wins a priority contest or a tie. The same holds for the lowest-pad rule on inputs, the exact two-edge latency of a write, and the rule that out-of-range writes are ignored.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  // Maximum of two widths, used to size the write data bus.
  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs #(
  parameter int unsigned NUM_CORE = 4,
  parameter int unsigned NUM_PAD  = 4,
  parameter int unsigned PRIO_W   = 2,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_PAD-1:0][NUM_CORE-1:0]    pad_mask,
  output logic [NUM_CORE-1:0][PRIO_W-1:0]     core_prio
);

  // Per-pad enable masks at addresses 0 .. NUM_PAD-1
  for (genvar p = 0; p < NUM_PAD; p++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)
        pad_mask[p] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(p)))
        pad_mask[p] <= wr_data[NUM_CORE-1:0];
    end
  end

  // Per-core priorities at addresses NUM_PAD .. NUM_PAD+NUM_CORE-1
  for (genvar c = 0; c < NUM_CORE; c++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst)
        core_prio[c] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(NUM_PAD + c)))
        core_prio[c] <= wr_data[PRIO_W-1:0];
    end
  end

endmodule

// File: rtl/pinmux_arbiter.sv
module pinmux_arbiter #(
  parameter int unsigned NUM_CORE = 4,
  parameter int unsigned PRIO_W   = 2
) (
  input  logic [NUM_CORE-1:0]             mask,
  input  logic [NUM_CORE-1:0][PRIO_W-1:0] prio,
  output logic [NUM_CORE-1:0]             grant
);

  logic              found;
  logic [PRIO_W-1:0] best;

  // Strictly-greater compare keeps the lowest index on a tie.
  always_comb begin
    grant = '0;
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < NUM_CORE; i++) begin
      if (mask[i] && (!found || (prio[i] > best))) begin
        grant    = '0;
        grant[i] = 1'b1;
        best     = prio[i];
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pinmux_route.sv
module pinmux_route #(
  parameter int unsigned          NUM_CORE   = 4,
  parameter int unsigned          NUM_PAD    = 4,
  parameter logic [NUM_CORE-1:0]  DEFAULT_IN = '0
) (
  input  logic [NUM_PAD-1:0][NUM_CORE-1:0] owner,
  input  logic [NUM_CORE-1:0]              core_out,
  input  logic [NUM_CORE-1:0]              core_oe_n,
  input  logic [NUM_PAD-1:0]               pad_in,
  output logic [NUM_PAD-1:0]               func_out,
  output logic [NUM_PAD-1:0]               func_oe_n,
  output logic [NUM_CORE-1:0]              core_in
);

  // Outbound: one AND-OR level per pad on a one-hot owner vector
  for (genvar p = 0; p < NUM_PAD; p++) begin : g_out
    assign func_out[p]  = |(owner[p] & core_out);
    assign func_oe_n[p] = ~(|(owner[p] & ~core_oe_n));
  end

  // Inbound: lowest owning pad wins, otherwise the default bit
  for (genvar c = 0; c < NUM_CORE; c++) begin : g_in
    always_comb begin
      core_in[c] = DEFAULT_IN[c];
      for (int p = NUM_PAD - 1; p >= 0; p--) begin
        if (owner[p][c])
          core_in[c] = pad_in[p];
      end
    end
  end

endmodule

// File: rtl/pinmux_fabric.sv
module pinmux_fabric #(
  parameter int unsigned          NUM_CORE   = 4,
  parameter int unsigned          NUM_PAD    = 4,
  parameter int unsigned          PRIO_W     = 2,
  parameter logic [NUM_CORE-1:0]  DEFAULT_IN = 4'b1001,
  parameter int unsigned          ADDR_W     = $clog2(NUM_PAD + NUM_CORE) + 1,
  parameter int unsigned          DATA_W     = pinmux_pkg::max_w(NUM_CORE, PRIO_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [NUM_CORE-1:0] core_out,
  input  logic [NUM_CORE-1:0] core_oe_n,
  output logic [NUM_CORE-1:0] core_in,
  input  logic [NUM_PAD-1:0]  pad_in,
  output logic [NUM_PAD-1:0]  pad_out,
  output logic [NUM_PAD-1:0]  pad_oe_n,
  input  logic                test_mode,
  input  logic [NUM_PAD-1:0]  test_out,
  input  logic [NUM_PAD-1:0]  test_oe_n
);

  logic [NUM_PAD-1:0][NUM_CORE-1:0] pad_mask;
  logic [NUM_CORE-1:0][PRIO_W-1:0]  core_prio;
  logic [NUM_PAD-1:0][NUM_CORE-1:0] grant;
  logic [NUM_PAD-1:0][NUM_CORE-1:0] owner_q;
  logic [NUM_PAD-1:0]               func_out;
  logic [NUM_PAD-1:0]               func_oe_n;

  pinmux_cfg_regs #(
    .NUM_CORE(NUM_CORE), .NUM_PAD(NUM_PAD), .PRIO_W(PRIO_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pad_mask(pad_mask), .core_prio(core_prio)
  );

  // Per-pad owner resolution, registered to keep it off the data path
  for (genvar p = 0; p < NUM_PAD; p++) begin : g_pad
    pinmux_arbiter #(.NUM_CORE(NUM_CORE), .PRIO_W(PRIO_W)) u_arb (
      .mask(pad_mask[p]), .prio(core_prio), .grant(grant[p])
    );

    always_ff @(posedge clk) begin
      if (rst) owner_q[p] <= '0;
      else     owner_q[p] <= grant[p];
    end
  end

  pinmux_route #(
    .NUM_CORE(NUM_CORE), .NUM_PAD(NUM_PAD), .DEFAULT_IN(DEFAULT_IN)
  ) u_route (
    .owner(owner_q), .core_out(core_out), .core_oe_n(core_oe_n), .pad_in(pad_in),
    .func_out(func_out), .func_oe_n(func_oe_n), .core_in(core_in)
  );

  // Final stage: test path overrides the functional path at the pad
  assign pad_out  = test_mode ? test_out  : func_out;
  assign pad_oe_n = test_mode ? test_oe_n : func_oe_n;

endmodule

// File: rtl/pinmux_fabric_chk.sv
module pinmux_fabric_chk #(
  parameter int unsigned          NUM_CORE   = 4,
  parameter int unsigned          NUM_PAD    = 4,
  parameter logic [NUM_CORE-1:0]  DEFAULT_IN = '0
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               wr_en,
  input logic                               test_mode,
  input logic [NUM_PAD-1:0]                 test_out,
  input logic [NUM_PAD-1:0]                 test_oe_n,
  input logic [NUM_PAD-1:0]                 pad_out,
  input logic [NUM_PAD-1:0]                 pad_oe_n,
  input logic [NUM_CORE-1:0]                core_in,
  input logic [NUM_PAD-1:0][NUM_CORE-1:0]   owner
);

  logic [NUM_CORE-1:0] claimed;
  always_comb begin
    claimed = '0;
    for (int p = 0; p < NUM_PAD; p++) claimed = claimed | owner[p];
  end

  for (genvar p = 0; p < NUM_PAD; p++) begin : g_pad_chk
    // R4/R5: priority resolution yields at most one owner per pad
    assert_single_owner_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(owner[p]));

    // R6: an unowned pad is tristated and low in functional mode
    assert_idle_pad_R6: assert property (@(posedge clk) disable iff (rst)
      (!test_mode && (owner[p] == '0)) |-> (pad_oe_n[p] && !pad_out[p]));
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core_chk
    // R8: unowned core pin reads its default
    assert_default_in_R8: assert property (@(posedge clk) disable iff (rst)
      !claimed[c] |-> (core_in[c] == DEFAULT_IN[c]));
  end

  // R9: test path owns the pads in test mode
  assert_test_path_R9: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> ((pad_out == test_out) && (pad_oe_n == test_oe_n)));

  // R1: the cycle after reset leaves every pad tristated
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !test_mode) |-> (&pad_oe_n));

  // R2: routing changes only as a result of a write
  assert_no_spurious_change_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(wr_en, 2) && !$past(rst)) |-> $stable(owner));

endmodule

bind pinmux_fabric pinmux_fabric_chk #(
  .NUM_CORE(NUM_CORE), .NUM_PAD(NUM_PAD), .DEFAULT_IN(DEFAULT_IN)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .test_mode(test_mode),
  .test_out(test_out), .test_oe_n(test_oe_n), .pad_out(pad_out),
  .pad_oe_n(pad_oe_n), .core_in(core_in), .owner(owner_q)
);

// File: tb/pinmux_fabric_bench.sv
`timescale 1ns/1ps
module pinmux_fabric_bench;

  localparam int M = 4;
  localparam int N = 4;
  localparam int PW = 2;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam logic [M-1:0] DEF = 4'b1001;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [M-1:0]  core_out = '0, core_oe_n = '1, core_in;
  logic [N-1:0]  pad_in = '0, pad_out, pad_oe_n;
  logic          test_mode = 1'b0;
  logic [N-1:0]  test_out = '0, test_oe_n = '1;

  int tests = 0;
  int fails = 0;

  logic [M-1:0]  mask_m [N];
  logic [PW-1:0] prio_m [M];

  always #2.5 clk = ~clk;

  pinmux_fabric #(.NUM_CORE(M), .NUM_PAD(N), .PRIO_W(PW), .DEFAULT_IN(DEF)) u_pinmux_fabric (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .core_out(core_out), .core_oe_n(core_oe_n), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe_n(pad_oe_n),
    .test_mode(test_mode), .test_out(test_out), .test_oe_n(test_oe_n)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_owner(input int p);
    int best = -1;
    for (int c = 0; c < M; c++)
      if (mask_m[p][c] && (best < 0 || prio_m[c] > prio_m[best])) best = c;
    return best;
  endfunction

  task automatic check_all(input string req);
    logic [N-1:0] e_out, e_oe;
    logic [M-1:0] e_in;
    e_in = DEF;
    for (int p = 0; p < N; p++) begin
      int o = ref_owner(p);
      e_out[p] = test_mode ? test_out[p]  : (o < 0 ? 1'b0 : core_out[o]);
      e_oe[p]  = test_mode ? test_oe_n[p] : (o < 0 ? 1'b1 : core_oe_n[o]);
    end
    for (int p = N - 1; p >= 0; p--) begin
      int o = ref_owner(p);
      if (o >= 0) e_in[o] = pad_in[p];
    end
    chk(req, "pad_out", 32'(pad_out), 32'(e_out));
    chk(req, "pad_oe_n", 32'(pad_oe_n), 32'(e_oe));
    chk(req, "core_in", 32'(core_in), 32'(e_in));
  endtask

  // Write and update the bench model; returns at the negedge after the write edge
  task automatic cfg_write(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < N) mask_m[addr] = data[M-1:0];
    else if (addr < N + M) prio_m[addr-N] = data[PW-1:0];
  endtask

  task automatic settle();
    @(negedge clk); #0.5;
  endtask

  task automatic drive(input logic [M-1:0] co, input logic [M-1:0] coe, input logic [N-1:0] pi);
    core_out = co; core_oe_n = coe; pad_in = pi; #0.5;
  endtask

  task automatic clear_all();
    for (int a = 0; a < N + M; a++) cfg_write(a, '0);
    settle();
  endtask

  task automatic t_reset();
    drive(4'b1111, 4'b0000, 4'b0110);
    chk("R1", "pad_oe_n after reset", 32'(pad_oe_n), 32'hF);
    chk("R1", "pad_out after reset", 32'(pad_out), 32'h0);
    chk("R1", "core_in after reset", 32'(core_in), 32'(DEF));
    check_all("R1");
  endtask

  task automatic t_any_to_any();
    for (int p = 0; p < N; p++)
      for (int c = 0; c < M; c++) begin
        cfg_write(p, DW'(1 << c)); settle();
        drive(4'b0101, 4'b1010, 4'b0011); check_all("R3");
        drive(4'b1010, 4'b0101, 4'b1100); check_all("R3");
        cfg_write(p, '0); settle();
      end
  endtask

  task automatic t_latency();
    drive(4'b0100, 4'b0000, 4'b0000);
    cfg_write(1, 4'b0100);
    #0.5;
    chk("R2", "pad1 oe_n before second edge", 32'(pad_oe_n[1]), 32'h1);
    settle();
    chk("R2", "pad1 oe_n after second edge", 32'(pad_oe_n[1]), 32'h0);
    chk("R2", "pad1 out after second edge", 32'(pad_out[1]), 32'h1);
    clear_all();
  endtask

  task automatic t_priority();
    cfg_write(0, 4'b1111);
    cfg_write(N + 0, 2'd1); cfg_write(N + 1, 2'd1);
    cfg_write(N + 2, 2'd3); cfg_write(N + 3, 2'd2);
    settle();
    drive(4'b0100, 4'b1011, 4'b0001);
    chk("R4", "pad0 out (core2 wins)", 32'(pad_out[0]), 32'h1);
    chk("R4", "pad0 oe_n (core2 wins)", 32'(pad_oe_n[0]), 32'h0);
    check_all("R4");
    cfg_write(0, 4'b1011); settle();
    drive(4'b1000, 4'b0111, 4'b0001);
    chk("R4", "pad0 out (core3 wins)", 32'(pad_out[0]), 32'h1);
    check_all("R4");
    clear_all();
  endtask

  task automatic t_tie();
    cfg_write(2, 4'b0110); settle();
    drive(4'b0010, 4'b1101, 4'b0100);
    chk("R5", "pad2 out (core1 on tie)", 32'(pad_out[2]), 32'h1);
    chk("R5", "core_in core1", 32'(core_in[1]), 32'h1);
    check_all("R5");
    cfg_write(N + 0, 2'd2); cfg_write(N + 3, 2'd2); cfg_write(2, 4'b1001); settle();
    drive(4'b0001, 4'b0110, 4'b0000);
    chk("R5", "pad2 out (core0 on tie)", 32'(pad_out[2]), 32'h1);
    check_all("R5");
    clear_all();
  endtask

  task automatic t_input();
    cfg_write(1, 4'b0100); cfg_write(3, 4'b0100); settle();
    drive(4'b0000, 4'b1111, 4'b1000);
    chk("R7", "core_in2 from pad1 (0)", 32'(core_in[2]), 32'h0);
    drive(4'b0000, 4'b1111, 4'b0010);
    chk("R7", "core_in2 from pad1 (1)", 32'(core_in[2]), 32'h1);
    check_all("R7");
    clear_all();
  endtask

  task automatic t_defaults();
    cfg_write(0, 4'b0010); settle();
    drive(4'b0000, 4'b1111, 4'b1111);
    chk("R8", "unowned core_in high pads", 32'(core_in & 4'b1101), 32'(DEF & 4'b1101));
    drive(4'b0000, 4'b1111, 4'b0000);
    chk("R8", "unowned core_in low pads", 32'(core_in & 4'b1101), 32'(DEF & 4'b1101));
    check_all("R8");
    clear_all();
    drive(4'b0000, 4'b0000, 4'b1111);
    chk("R6", "all pads idle oe_n", 32'(pad_oe_n), 32'hF);
    chk("R6", "all pads idle out", 32'(pad_out), 32'h0);
  endtask

  task automatic t_test_mode();
    cfg_write(0, 4'b0001); cfg_write(2, 4'b1000); settle();
    drive(4'b1001, 4'b0000, 4'b0101);
    test_mode = 1'b1; test_out = 4'b0110; test_oe_n = 4'b1010; #0.5;
    chk("R9", "pad_out test", 32'(pad_out), 32'h6);
    chk("R9", "pad_oe_n test", 32'(pad_oe_n), 32'hA);
    chk("R9", "core_in in test", 32'(core_in), 32'((DEF & 4'b0110) | 4'b1001));
    check_all("R9");
    test_mode = 1'b0; #0.5;
    check_all("R9");
    clear_all();
  endtask

  task automatic t_bad_addr();
    cfg_write(1, 4'b0001); settle();
    for (int a = N + M; a < (1 << AW); a++) cfg_write(a, '1);
    settle();
    drive(4'b0001, 4'b1110, 4'b0010);
    chk("R10", "pad1 still core0", 32'(pad_out[1]), 32'h1);
    chk("R10", "other pads idle", 32'(pad_oe_n & 4'b1101), 32'hD);
    check_all("R10");
    clear_all();
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 40; k++) begin
      cfg_write($urandom_range(N + M - 1), DW'($urandom));
      settle();
      drive(M'($urandom), M'($urandom), N'($urandom));
      check_all("R3 R4 R5 R7 sweep");
    end
    clear_all();
  endtask

  initial begin
    for (int p = 0; p < N; p++) mask_m[p] = '0;
    for (int c = 0; c < M; c++) prio_m[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_latency();
    t_any_to_any();
    t_priority();
    t_tie();
    t_input();
    t_defaults();
    t_test_mode();
    t_bad_addr();
    t_sweep();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule